// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Temperature Register Slave

This block is a slave on a two-wire serial bus. Its system clock samples SCL and SDA. A host uses the block to reach a small register file. The register file holds four registers:

- a read-only 9-bit temperature word, taken live from an input port;
- a setpoint threshold (9 bits);
- a hysteresis threshold (9 bits);
- an 8-bit configuration byte.

In a write transfer, the first byte after the address loads an internal pointer, and any bytes that follow go to the selected register. A read transfer returns the register the pointer last selected. If a pointer write is followed by a repeated START, the read returns the newly selected register.

The block answers to a 7-bit address. The upper four bits of that address are fixed, and the lower three come from strap pins. The block drives SDA only by pulling it low through an enable output. It pulses a strobe each time a host read ends. Neighbouring alarm logic uses that strobe to clear a latched event, and takes the threshold and configuration values straight from the output ports.

Top module: `tsense_i2c_slave`

## Requirements
- R1: The slave responds only to the address byte whose upper seven bits equal 1001 followed by `addr_sel_i[2:0]`. For any other address it gives no acknowledge and keeps SDA released until the next START.
- R2: Bytes are shifted MSB first, and each byte is followed by a ninth acknowledge clock. `sda_oe_o`=1 pulls SDA low, and `sda_oe_o` changes only while SCL is low. After an address match, the slave acknowledges the address byte and every byte written to it.
- R3: The first byte written after the address sets the pointer from its bits 1:0, with 00 selecting temperature, 01 configuration, 10 hysteresis and 11 setpoint. The pointer survives across transfers, so a read with no pointer write returns the register last selected.
- R4: A two-byte register value V of 9 bits is read as a high byte V[8:1] followed by a low byte {V[0], 7'b0}.
- R5: A write to the setpoint or hysteresis register takes effect only after both data bytes have arrived, and stores {first byte, bit 7 of second byte}. A transfer that stops after the first data byte leaves the register unchanged.
- R6: The configuration register is one byte. Bits 7:5 are always stored as zero, and bits 4:0 are stored as written and read back unchanged.
- R7: Writes to the temperature register are acknowledged and have no effect. Reads of it return the current `temp_i`.
- R8: After reset the setpoint is 0x0A0 (80 degC), the hysteresis is 0x096 (75 degC), the configuration is 0x00, the pointer is 00 and SDA is released.
- R9: `rd_strobe_o` is a single-cycle pulse. It is issued once per read transfer, when the master does not acknowledge a byte, and never during write transfers.
- R10: Setting configuration bit 0 (shutdown) does not block any bus access.
- R11: START and STOP are recognised only when SDA changes while SCL is high, after two-stage synchronisation. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 3 | Strap value for the low address bits |
| temp_i | input | 9 | Current temperature, two's complement, 0.5 degC per LSB |
| rd_strobe_o | output | 1 | One-cycle pulse when a host read ends |
| cfg_o | output | 8 | Configuration register |
| tset_o | output | 9 | Setpoint register |
| thyst_o | output | 9 | Hysteresis register |

## Verification
A corrupted pointer or byte index shows up on the very next read: the bytes come back from the wrong register, or the low and high halves are swapped. Such a fault is visible within one 9-clock byte window. Bit-counter or state errors show as missing or misplaced acknowledge bits in the same byte. Commit-logic errors appear on `tset_o` or `thyst_o` a few system cycles after the ninth clock, as a premature update or a missing update. A strobe error shows as a count mismatch right after the NACK.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } link_st_e;

  localparam logic [3:0] DEV_ID   = 4'b1001;
  localparam logic [1:0] PTR_TEMP = 2'b00;
  localparam logic [1:0] PTR_CFG  = 2'b01;
  localparam logic [1:0] PTR_HYST = 2'b10;
  localparam logic [1:0] PTR_SET  = 2'b11;
  localparam int unsigned WORD_W  = 16;
endpackage

// File: rtl/tsi_bus_sync.sv
module tsi_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_ff[SYNC_STAGES-1];
      sda_prev <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o   = scl_ff[SYNC_STAGES-1];
  assign sda_o   = sda_ff[SYNC_STAGES-1];
  assign rise_o  = scl_o & ~scl_prev;
  assign fall_o  = ~scl_o & scl_prev;
  // data edges while clock held high
  assign start_o = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o  = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/tsi_link.sv
module tsi_link
  import tsi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] addr_sel_i,
  input  logic [7:0] rd_hi_i,
  input  logic [7:0] rd_lo_i,
  output logic       wr_stb_o,
  output logic [1:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       rd_done_o,
  output logic       sda_oe_o
);
  link_st_e   state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] tx;
  logic       rw, rd_sel, nack;
  logic [1:0] widx;

  logic [7:0] next_rd;
  assign next_rd = rd_sel ? rd_hi_i : rd_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      rd_sel    <= 1'b0;
      nack      <= 1'b0;
      widx      <= '0;
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      rd_done_o <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      rd_done_o <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (fall_i && cnt == 4'd8) begin
              if (sh[7:1] == {DEV_ID, addr_sel_i}) begin
                state    <= ST_AACK;
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (fall_i) begin
              cnt <= '0;
              if (rw) begin
                state    <= ST_RD;
                rd_sel   <= 1'b0;
                tx       <= rd_hi_i[6:0];
                sda_oe_o <= ~rd_hi_i[7];
              end else begin
                state    <= ST_WR;
                sda_oe_o <= 1'b0;
                widx     <= '0;
              end
            end
          end
          ST_WR: begin
            if (rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (fall_i && cnt == 4'd8) begin
              wr_stb_o  <= 1'b1;
              wr_data_o <= sh;
              wr_idx_o  <= widx;
              if (widx != 2'd3) widx <= widx + 2'd1;
              state     <= ST_WACK;
              sda_oe_o  <= 1'b1;
            end
          end
          ST_WACK: begin
            if (fall_i) begin
              state    <= ST_WR;
              sda_oe_o <= 1'b0;
              cnt      <= '0;
            end
          end
          ST_RD: begin
            if (rise_i) begin
              cnt <= cnt + 4'd1;
            end else if (fall_i) begin
              if (cnt == 4'd8) begin
                state    <= ST_RACK;
                sda_oe_o <= 1'b0;
              end else if (cnt != 4'd0) begin
                sda_oe_o <= ~tx[6];
                tx       <= {tx[5:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (rise_i) begin
              nack <= sda_i;
            end else if (fall_i) begin
              if (nack) begin
                state     <= ST_IDLE;
                rd_done_o <= 1'b1;
              end else begin
                state    <= ST_RD;
                cnt      <= '0;
                rd_sel   <= ~rd_sel;
                tx       <= next_rd[6:0];
                sda_oe_o <= ~next_rd[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsi_regfile.sv
module tsi_regfile
  import tsi_pkg::*;
#(
  parameter int unsigned        TEMP_W    = 9,
  parameter int unsigned        CFG_BITS  = 5,
  parameter logic [TEMP_W-1:0]  TSET_RST  = 9'h0A0,
  parameter logic [TEMP_W-1:0]  THYST_RST = 9'h096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [1:0]        wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [7:0]        rd_hi_o,
  output logic [7:0]        rd_lo_o,
  output logic [7:0]        cfg_o,
  output logic [TEMP_W-1:0] tset_o,
  output logic [TEMP_W-1:0] thyst_o
);
  localparam int unsigned PAD      = WORD_W - TEMP_W;
  localparam int unsigned LSB_TAKE = TEMP_W - 8;

  logic [1:0]        ptr;
  logic [7:0]        msb_hold;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr      <= PTR_TEMP;
      msb_hold <= '0;
      cfg_o    <= '0;
      tset_o   <= TSET_RST;
      thyst_o  <= THYST_RST;
    end else if (wr_stb_i) begin
      unique case (wr_idx_i)
        2'd0: ptr <= wr_data_i[1:0];
        2'd1: begin
          if (ptr == PTR_CFG) cfg_o <= {{(8-CFG_BITS){1'b0}}, wr_data_i[CFG_BITS-1:0]};
          else msb_hold <= wr_data_i;
        end
        2'd2: begin
          if (ptr == PTR_SET)  tset_o  <= {msb_hold, wr_data_i[7 -: LSB_TAKE]};
          if (ptr == PTR_HYST) thyst_o <= {msb_hold, wr_data_i[7 -: LSB_TAKE]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ptr)
      PTR_TEMP: rd_word = {temp_i, {PAD{1'b0}}};
      PTR_HYST: rd_word = {thyst_o, {PAD{1'b0}}};
      PTR_SET:  rd_word = {tset_o, {PAD{1'b0}}};
      default:  rd_word = {cfg_o, cfg_o};
    endcase
  end

  assign rd_hi_o = rd_word[WORD_W-1 -: 8];
  assign rd_lo_o = rd_word[7:0];
endmodule

// File: rtl/tsense_i2c_slave.sv
module tsense_i2c_slave #(
  parameter int unsigned       TEMP_W      = 9,
  parameter int unsigned       CFG_BITS    = 5,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [TEMP_W-1:0] TSET_RST    = 9'h0A0,
  parameter logic [TEMP_W-1:0] THYST_RST   = 9'h096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        addr_sel_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              rd_strobe_o,
  output logic [7:0]        cfg_o,
  output logic [TEMP_W-1:0] tset_o,
  output logic [TEMP_W-1:0] thyst_o
);
  logic scl_s, sda_s, rise, fall, start, stop;
  logic       wr_stb;
  logic [1:0] wr_idx;
  logic [7:0] wr_data, rd_hi, rd_lo;

  tsi_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  tsi_link link_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_i(sda_s), .rise_i(rise), .fall_i(fall),
    .start_i(start), .stop_i(stop), .addr_sel_i(addr_sel_i),
    .rd_hi_i(rd_hi), .rd_lo_i(rd_lo), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .rd_done_o(rd_strobe_o), .sda_oe_o(sda_oe_o)
  );

  tsi_regfile #(
    .TEMP_W(TEMP_W), .CFG_BITS(CFG_BITS), .TSET_RST(TSET_RST), .THYST_RST(THYST_RST)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_stb_i(wr_stb), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .temp_i(temp_i), .rd_hi_o(rd_hi), .rd_lo_o(rd_lo),
    .cfg_o(cfg_o), .tset_o(tset_o), .thyst_o(thyst_o)
  );
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
  parameter int unsigned TEMP_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_o,
  input logic              rd_strobe_o,
  input logic [7:0]        cfg_o,
  input logic [TEMP_W-1:0] tset_o,
  input logic [TEMP_W-1:0] thyst_o,
  input logic              scl_s,
  input logic              wr_stb,
  input logic [1:0]        wr_idx
);
  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_o |=> !rd_strobe_o);

  assert_oe_scl_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

  assert_tset_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tset_o) |-> $past(wr_stb && wr_idx == 2'd2));

  assert_thyst_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(thyst_o) |-> $past(wr_stb && wr_idx == 2'd2));

  assert_cfg_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(wr_stb && wr_idx == 2'd1));
endmodule

bind tsense_i2c_slave tsi_checker #(.TEMP_W(TEMP_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .rd_strobe_o(rd_strobe_o),
  .cfg_o(cfg_o), .tset_o(tset_o), .thyst_o(thyst_o), .scl_s(scl_s),
  .wr_stb(wr_stb), .wr_idx(wr_idx)
);

// File: tb/tsense_i2c_slave_tb_top.sv
module tsense_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] WADDR = {4'b1001, SEL, 1'b0};
  localparam logic [7:0] RADDR = {4'b1001, SEL, 1'b1};
  // {pointer, first byte, second byte}; config entries use only the first byte
  localparam logic [17:0] VEC [6] = '{
    {2'b11, 16'h6480}, {2'b10, 16'hFF00}, {2'b01, 16'hFF00},
    {2'b11, 16'h8000}, {2'b01, 16'h0500}, {2'b10, 16'h0080}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [8:0] temp = 9'h032;
  logic sda_oe, rd_stb;
  logic [7:0] cfg;
  logic [8:0] tset, thyst;
  wire sda_line = sda_m & ~sda_oe;
  int n_tests = 0, n_fail = 0, stb_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && rd_stb) stb_cnt <= stb_cnt + 1;

  tsense_i2c_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(SEL), .temp_i(temp), .rd_strobe_o(rd_stb), .cfg_o(cfg),
    .tset_o(tset), .thyst_o(thyst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(last);
  endtask

  task automatic do_write(input logic [1:0] ptr, input int n, input logic [7:0] b0,
                          input logic [7:0] b1, output int acks);
    logic a;
    acks = 0;
    bus_start();
    put_byte(WADDR, a); acks += int'(a);
    put_byte({6'b0, ptr}, a); acks += int'(a);
    if (n > 0) begin put_byte(b0, a); acks += int'(a); end
    if (n > 1) begin put_byte(b1, a); acks += int'(a); end
    bus_stop();
  endtask

  task automatic do_read(input logic set_ptr, input logic [1:0] ptr, input int n,
                         output logic [7:0] r0, output logic [7:0] r1);
    logic a;
    r1 = 8'h00;
    bus_start();
    if (set_ptr) begin
      put_byte(WADDR, a);
      put_byte({6'b0, ptr}, a);
      bus_start();
    end
    put_byte(RADDR, a);
    get_byte(n == 1, r0);
    if (n > 1) get_byte(1'b1, r1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1;
    logic a;
    int acks, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R8 sda released", int'(sda_oe), 0);
    chk("R8 setpoint reset", int'(tset), 'h0A0);
    chk("R8 hysteresis reset", int'(thyst), 'h096);
    chk("R8 config reset", int'(cfg), 0);
    chk("R9 no strobe at reset", int'(rd_stb), 0);

    // R3 R4: default pointer selects temperature
    s0 = stb_cnt;
    do_read(1'b0, 2'b00, 2, r0, r1);
    chk("R3 R4 temp hi default ptr", int'(r0), 'h19);
    chk("R4 temp lo", int'(r1), 'h00);
    chk("R9 one strobe per read", stb_cnt - s0, 1);

    // R1: wrong address not acknowledged
    bus_start();
    put_byte({4'b1001, 3'b110, 1'b0}, a);
    chk("R1 wrong address nack", int'(a), 0);
    chk("R1 sda released after miss", int'(sda_oe), 0);
    bus_stop();
    bus_start();
    put_byte({4'b1101, SEL, 1'b0}, a);
    chk("R1 wrong fixed bits nack", int'(a), 0);
    bus_stop();

    // table: write then repeated-start read back (R2 R5 R6 R10 R11)
    foreach (VEC[k]) begin
      logic [1:0] p;
      logic [7:0] b0, b1;
      int n;
      p = VEC[k][17:16]; b0 = VEC[k][15:8]; b1 = VEC[k][7:0];
      n = (p == 2'b01) ? 1 : 2;
      s0 = stb_cnt;
      do_write(p, n, b0, b1, acks);
      chk("R2 all written bytes acked", acks, n + 2);
      chk("R9 no strobe on write", stb_cnt - s0, 0);
      do_read(1'b1, p, n, r0, r1);
      if (p == 2'b01) begin
        chk("R6 config readback", int'(r0), int'(b0 & 8'h1F));
        chk("R6 config port", int'(cfg), int'(b0 & 8'h1F));
      end else begin
        chk("R11 R4 R10 readback hi", int'(r0), int'(b0));
        chk("R4 R10 readback lo", int'(r1), int'({b1[7], 7'b0}));
        if (p == 2'b11) chk("R5 setpoint port", int'(tset), int'({b0, b1[7]}));
        else chk("R5 hysteresis port", int'(thyst), int'({b0, b1[7]}));
      end
      chk("R9 strobe per read", stb_cnt - s0, 1);
    end

    // R3: pointer persists (last selected hysteresis = 0x001)
    do_read(1'b0, 2'b00, 2, r0, r1);
    chk("R3 preset pointer hi", int'(r0), 'h00);
    chk("R3 preset pointer lo", int'(r1), 'h80);

    // R7: temperature write ignored; reads follow temp_i
    temp = 9'h1CE;
    do_write(2'b00, 2, 8'h12, 8'h34, acks);
    chk("R7 temp write acked", acks, 4);
    do_read(1'b0, 2'b00, 2, r0, r1);
    chk("R7 temp read hi", int'(r0), 'hE7);
    chk("R7 temp read lo", int'(r1), 'h00);
    temp = 9'h001;
    do_read(1'b0, 2'b00, 2, r0, r1);
    chk("R4 temp lsb hi", int'(r0), 'h00);
    chk("R4 temp lsb lo", int'(r1), 'h80);

    // R5: partial write must not commit
    do_write(2'b11, 1, 8'h11, 8'h00, acks);
    chk("R5 partial write keeps setpoint", int'(tset), 'h100);
    do_read(1'b1, 2'b11, 2, r0, r1);
    chk("R5 partial write readback", int'(r0), 'h80);

    // R6: config single byte, upper bits zero
    do_write(2'b01, 1, 8'hE2, 8'h00, acks);
    do_read(1'b0, 2'b00, 1, r0, r1);
    chk("R6 config mask", int'(r0), 'h02);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule